// File: doc/BRIEF.md
# DRAM Module Global Switch

This block stands beside one DRAM module and terminates the global request channels coming from every core group. Each group channel delivers a request message as a fixed number of flits; the flits land in a private input buffer for that group. Once a buffer holds a whole message, a round-robin arbiter may select it. The chosen message is then streamed, flit by flit, to the memory side, and every flit carries the number of the group it came from.

A fixed-latency memory model answers each request. The response is steered back onto the return channel of the group that sent the request. The first flit of that response carries a credit count, which tells the group how many flits of its input buffer have been freed since its last response. Credits therefore travel on the response path and need no link of their own. If a group writes into a full buffer, the flit is dropped and an overflow flag for that group is raised for one cycle.

Only one message is in flight at a time. The switch forwards a request, waits out the memory latency, returns the response, and only then grants the next message.

Top module: `msw_switch`

## Requirements
- R1: After reset, every valid output, every response flit, every credit field and every overflow flag is zero.
- R2: A group's buffer is eligible for arbitration only once it holds MSG_BITS/FLIT_W flits (4 with the default sizes). A partial message is never forwarded.
- R3: A granted message is forwarded as 4 consecutive `mem_req_valid_o` flits, in arrival order, with `mem_req_grp_o` equal to the source group index. No other request flit is forwarded until that message's response has ended.
- R4: Arbitration is round-robin. After group g has been served, the next grant goes to the first group holding a complete message in the order g+1, g+2, ..., wrapping from G-1 to 0. After reset, the search starts at group 0.
- R5: The first response flit appears exactly LAT cycles after the cycle of the tail request flit (100 by default).
- R6: Response flit k is the bitwise complement of request flit k of the same message.
- R7: A response is driven only on the return channel of the requesting group (bit g of `grp_out_valid_o`, flit slice [g*W +: W]). At most one channel is valid in any cycle, and all other flit slices are zero.
- R8: The credit field of group g (bits [g*CW +: CW], CW=4) equals the number of flits read out of group g's buffer since its previous response. It is nonzero only on the first response flit and reads zero on every other flit. The per-group count is cleared when it is returned.
- R9: A flit written to a buffer that already holds DEPTH flits (8) is dropped and not stored, and bit g of `grp_overflow_o` is high for exactly the following cycle. Buffered flits are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| grp_in_valid_i | input | G | Per-group request flit valid |
| grp_in_flit_i | input | G*W | Per-group request flit, group g at [g*W +: W] |
| mem_req_valid_o | output | 1 | Request flit to the memory side is valid |
| mem_req_flit_o | output | W | Request flit to the memory side |
| mem_req_grp_o | output | $clog2(G) | Source group tag of the request flit |
| grp_out_valid_o | output | G | Per-group response flit valid |
| grp_out_flit_o | output | G*W | Per-group response flit |
| grp_out_credit_o | output | G*CW | Per-group returned credits, on the first response flit |
| grp_overflow_o | output | G | Per-group write-into-full-buffer flag |

## Verification
The assertions watch the following properties on every cycle:
- message contiguity and tag stability on the memory side, together with the absence of new request flits while a response is pending;
- the exact latency window between the tail request flit and the response;
- the one-hot, correctly tagged steering of responses;
- the confinement of credits to the first response flit.

Some properties can only be shown by the bench's scenarios, because they depend on data values and on stimulus history: the round-robin order (including wrap-around), the withholding of a partial message, the complemented response contents, the credit value, and the fact that an overflowing flit is dropped while buffered flits survive.

// File: rtl/msw_pkg.sv
package msw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } sw_state_e;
endpackage

// File: rtl/msw_infifo.sv
module msw_infifo #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [W-1:0]                 wr_data_i,
    input  logic                         rd_en_i,
    output logic [W-1:0]                 rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         overflow_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic full, wr_ok, rd_ok;

    always_comb begin
        full  = (q.cnt == CW'(DEPTH));
        wr_ok = wr_en_i && !full;
        rd_ok = rd_en_i && (q.cnt != '0);
        d     = q;
        if (wr_ok) begin
            d.mem[q.wp] = wr_data_i;
            d.wp        = q.wp + PW'(1);
        end
        if (rd_ok) begin
            d.rp = q.rp + PW'(1);
        end
        d.cnt = q.cnt + CW'(wr_ok) - CW'(rd_ok);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rd_data_o  = q.mem[q.rp];
    assign count_o    = q.cnt;
    assign overflow_o = wr_en_i && full;
endmodule

// File: rtl/msw_rr_arb.sv
module msw_rr_arb #(
    parameter int N = 16
) (
    input  logic [N-1:0]          req_i,
    input  logic [$clog2(N)-1:0]  last_i,
    output logic [$clog2(N)-1:0]  gnt_o,
    output logic                  any_o
);
    localparam int IW = $clog2(N);

    int idx;

    always_comb begin
        any_o = 1'b0;
        gnt_o = last_i;
        idx   = 0;
        for (int i = 1; i <= N; i++) begin
            idx = (int'(last_i) + i) % N;
            if (!any_o && req_i[idx]) begin
                any_o = 1'b1;
                gnt_o = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/msw_switch.sv
module msw_switch
    import msw_pkg::*;
#(
    parameter int G        = 16,
    parameter int W        = 64,
    parameter int MSG_BITS = 256,
    parameter int DEPTH    = 8,
    parameter int LAT      = 100
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [G-1:0]                      grp_in_valid_i,
    input  logic [G*W-1:0]                    grp_in_flit_i,
    output logic                              mem_req_valid_o,
    output logic [W-1:0]                      mem_req_flit_o,
    output logic [$clog2(G)-1:0]              mem_req_grp_o,
    output logic [G-1:0]                      grp_out_valid_o,
    output logic [G*W-1:0]                    grp_out_flit_o,
    output logic [G*$clog2(DEPTH+1)-1:0]      grp_out_credit_o,
    output logic [G-1:0]                      grp_overflow_o
);
    localparam int FPM = MSG_BITS / W;
    localparam int GW  = $clog2(G);
    localparam int BW  = $clog2(FPM);
    localparam int CW  = $clog2(DEPTH+1);
    localparam int TW  = $clog2(LAT+1);

    typedef struct packed {
        sw_state_e                state;
        logic [GW-1:0]            grp;
        logic [BW-1:0]            beat;
        logic [TW-1:0]            timer;
        logic [FPM-1:0][W-1:0]    msg;
        logic [G-1:0][CW-1:0]     credit;
        logic [GW-1:0]            rr_last;
        logic [G-1:0]             ovf;
    } sw_regs_t;

    sw_regs_t q, d;

    logic [W-1:0]  rd_data [G];
    logic [CW-1:0] count   [G];
    logic [G-1:0]  pop, complete, ovf_now;
    logic [GW-1:0] gnt;
    logic          gnt_any;

    for (genvar g = 0; g < G; g++) begin : g_grp
        assign pop[g]      = (q.state == ST_SEND) && (q.grp == GW'(g));
        assign complete[g] = (count[g] >= CW'(FPM));

        msw_infifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .wr_en_i    (grp_in_valid_i[g]),
            .wr_data_i  (grp_in_flit_i[g*W +: W]),
            .rd_en_i    (pop[g]),
            .rd_data_o  (rd_data[g]),
            .count_o    (count[g]),
            .overflow_o (ovf_now[g])
        );
    end

    msw_rr_arb #(.N(G)) i_arb (
        .req_i  (complete),
        .last_i (q.rr_last),
        .gnt_o  (gnt),
        .any_o  (gnt_any)
    );

    always_comb begin
        d     = q;
        d.ovf = ovf_now;
        for (int g = 0; g < G; g++) begin
            d.credit[g] = ((q.state == ST_RESP && q.beat == '0 && q.grp == GW'(g))
                           ? '0 : q.credit[g]) + CW'(pop[g]);
        end
        unique case (q.state)
            ST_IDLE: begin
                if (gnt_any) begin
                    d.state   = ST_SEND;
                    d.grp     = gnt;
                    d.beat    = '0;
                    d.rr_last = gnt;
                end
            end
            ST_SEND: begin
                d.msg[q.beat] = rd_data[q.grp];
                if (q.beat == BW'(FPM-1)) begin
                    d.state = ST_WAIT;
                    d.beat  = '0;
                    d.timer = TW'(LAT-1);
                end else begin
                    d.beat = q.beat + BW'(1);
                end
            end
            ST_WAIT: begin
                if (q.timer == TW'(1)) d.state = ST_RESP;
                else                   d.timer = q.timer - TW'(1);
            end
            ST_RESP: begin
                if (q.beat == BW'(FPM-1)) begin
                    d.state = ST_IDLE;
                    d.beat  = '0;
                end else begin
                    d.beat = q.beat + BW'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.rr_last <= GW'(G-1);
        end else begin
            q <= d;
        end
    end

    assign mem_req_valid_o = (q.state == ST_SEND);
    assign mem_req_flit_o  = (q.state == ST_SEND) ? rd_data[q.grp] : '0;
    assign mem_req_grp_o   = q.grp;
    assign grp_overflow_o  = q.ovf;

    always_comb begin
        for (int g = 0; g < G; g++) begin
            grp_out_valid_o[g]           = (q.state == ST_RESP) && (q.grp == GW'(g));
            grp_out_flit_o[g*W +: W]     = grp_out_valid_o[g] ? ~q.msg[q.beat] : '0;
            grp_out_credit_o[g*CW +: CW] = (grp_out_valid_o[g] && q.beat == '0)
                                           ? q.credit[g] : '0;
        end
    end
endmodule

// File: rtl/msw_switch_sva.sv
module msw_switch_sva #(
    parameter int G        = 16,
    parameter int W        = 64,
    parameter int MSG_BITS = 256,
    parameter int DEPTH    = 8,
    parameter int LAT      = 100
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         mem_req_valid_o,
    input logic [$clog2(G)-1:0]         mem_req_grp_o,
    input logic [G-1:0]                 grp_out_valid_o,
    input logic [G*$clog2(DEPTH+1)-1:0] grp_out_credit_o
);
    localparam int FPM = MSG_BITS / W;
    localparam int BW  = $clog2(FPM);
    localparam int GW  = $clog2(G);
    localparam int TW  = $clog2(LAT+1);

    logic [BW-1:0] req_beats_q, resp_beats_q;
    logic [GW-1:0] last_tag_q, tail_grp_q;
    logic [TW-1:0] lat_cnt_q;
    logic          tail;

    assign tail = mem_req_valid_o && (req_beats_q == BW'(FPM-1));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_beats_q  <= '0;
            resp_beats_q <= '0;
            last_tag_q   <= '0;
            tail_grp_q   <= '0;
            lat_cnt_q    <= '0;
        end else begin
            if (mem_req_valid_o) begin
                req_beats_q <= tail ? '0 : req_beats_q + BW'(1);
                last_tag_q  <= mem_req_grp_o;
            end
            if (grp_out_valid_o != '0) begin
                resp_beats_q <= (resp_beats_q == BW'(FPM-1)) ? '0 : resp_beats_q + BW'(1);
            end
            if (tail) begin
                lat_cnt_q  <= TW'(1);
                tail_grp_q <= mem_req_grp_o;
            end else if (lat_cnt_q == TW'(LAT)) begin
                lat_cnt_q <= '0;
            end else if (lat_cnt_q != '0) begin
                lat_cnt_q <= lat_cnt_q + TW'(1);
            end
        end
    end

    a_r3_msg_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_beats_q != '0) |-> (mem_req_valid_o && mem_req_grp_o == last_tag_q));

    a_r3_no_req_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lat_cnt_q != '0 || resp_beats_q != '0) |-> !mem_req_valid_o);

    a_r5_no_early_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lat_cnt_q != '0 && lat_cnt_q < TW'(LAT)) |-> (grp_out_valid_o == '0));

    a_r5_resp_on_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lat_cnt_q == TW'(LAT)) |-> (grp_out_valid_o != '0));

    a_r7_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grp_out_valid_o));

    a_r7_tagged_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grp_out_valid_o != '0) |-> (grp_out_valid_o == (G'(1) << tail_grp_q)));

    a_r8_credit_head_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_beats_q != '0) |-> (grp_out_credit_o == '0));
endmodule

bind msw_switch msw_switch_sva #(
    .G(G), .W(W), .MSG_BITS(MSG_BITS), .DEPTH(DEPTH), .LAT(LAT)
) i_msw_switch_sva (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .mem_req_valid_o  (mem_req_valid_o),
    .mem_req_grp_o    (mem_req_grp_o),
    .grp_out_valid_o  (grp_out_valid_o),
    .grp_out_credit_o (grp_out_credit_o)
);

// File: tb/test_msw_switch.sv
module test_msw_switch;
    localparam int CLK_PERIOD = 10;
    localparam int G   = 16;
    localparam int W   = 64;
    localparam int FPM = 4;
    localparam int CW  = 4;
    localparam int LAT = 100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [G-1:0]    in_valid = '0;
    logic [G*W-1:0]  in_flit = '0;
    logic            req_valid;
    logic [W-1:0]    req_flit;
    logic [3:0]      req_grp;
    logic [G-1:0]    out_valid;
    logic [G*W-1:0]  out_flit;
    logic [G*CW-1:0] out_credit;
    logic [G-1:0]    ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int ovf7     = 0;
    int ovf_other = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msw_switch i_msw_switch (
        .clk_i(clk), .rst_ni(rst_n),
        .grp_in_valid_i(in_valid), .grp_in_flit_i(in_flit),
        .mem_req_valid_o(req_valid), .mem_req_flit_o(req_flit), .mem_req_grp_o(req_grp),
        .grp_out_valid_o(out_valid), .grp_out_flit_o(out_flit),
        .grp_out_credit_o(out_credit), .grp_overflow_o(ovf)
    );

    always @(negedge clk) if (rst_n) begin
        if (ovf[7]) ovf7++;
        if ((ovf & ~(G'(1) << 7)) != '0) ovf_other++;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fl(input logic [7:0] base, input int k);
        return {48'h0, base, 8'(k)};
    endfunction

    task automatic push(input int g, input logic [7:0] base, input int k0, input int n);
        for (int k = k0; k < k0 + n; k++) begin
            @(negedge clk);
            in_valid[g] = 1'b1;
            in_flit[g*W +: W] = fl(base, k);
        end
        @(negedge clk);
        in_valid[g] = 1'b0;
        in_flit[g*W +: W] = '0;
    endtask

    task automatic push_pair(input int ga, input logic [7:0] ba, input int gb, input logic [7:0] bb);
        for (int k = 0; k < FPM; k++) begin
            @(negedge clk);
            in_valid[ga] = 1'b1; in_flit[ga*W +: W] = fl(ba, k);
            in_valid[gb] = 1'b1; in_flit[gb*W +: W] = fl(bb, k);
        end
        @(negedge clk);
        in_valid = '0;
        in_flit  = '0;
    endtask

    // R2 R3 R5 R6 R7 R8: one full transaction as seen at the ports
    task automatic expect_xact(input int g, input logic [7:0] base, input int cred);
        int wait_n = 0;
        bit bad;
        while (!req_valid && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        for (int k = 0; k < FPM; k++) begin
            check(req_valid && req_grp == 4'(g), "R3/R4 request tag",
                  64'({req_valid, req_grp}), 64'({1'b1, 4'(g)}));
            check(req_flit == fl(base, k), "R3 request flit order", req_flit, fl(base, k));
            if (k < FPM-1) @(negedge clk);
        end
        bad = 0;
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            if (out_valid != '0 || req_valid) bad = 1;
        end
        check(!bad, "R5 quiet before latency", 64'(bad), 0);
        @(negedge clk);
        for (int k = 0; k < FPM; k++) begin
            check(out_valid == (G'(1) << g), "R5/R7 response channel", 64'(out_valid), 64'(G'(1) << g));
            check(out_flit[g*W +: W] == ~fl(base, k), "R6 response data",
                  out_flit[g*W +: W], ~fl(base, k));
            check((out_flit & ~({{(G-1)*W{1'b0}}, {W{1'b1}}} << (g*W))) == '0,
                  "R7 other channels quiet", 64'(out_flit != '0), 0);
            check(out_credit == ((k == 0 ? (G*CW)'(cred) : '0) << (g*CW)), "R8 credit field",
                  64'(out_credit[g*CW +: CW]), 64'(k == 0 ? cred : 0));
            @(negedge clk);
        end
    endtask

    localparam logic [11:0] VEC [5] = '{
        {4'd0,  8'h11},
        {4'd15, 8'h22},
        {4'd6,  8'hA5},
        {4'd11, 8'h3C},
        {4'd3,  8'h7E}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!req_valid && out_valid == '0 && out_flit == '0 && out_credit == '0 && ovf == '0,
              "R1 reset outputs", 64'(req_valid) | 64'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid && out_valid == '0, "R1 idle after reset", 64'(req_valid), 0);

        for (int v = 0; v < 5; v++) begin
            push(int'(VEC[v][11:8]), VEC[v][7:0], 0, FPM);
            expect_xact(int'(VEC[v][11:8]), VEC[v][7:0], FPM);
        end

        // R4: last served group 3, groups 2 and 5 ready -> 5 first, then 2
        push_pair(2, 8'h52, 5, 8'h55);
        expect_xact(5, 8'h55, FPM);
        expect_xact(2, 8'h52, FPM);
        // R4 wrap: last served 2, groups 1 and 0 ready -> 0 then 1
        push_pair(1, 8'h61, 0, 8'h60);
        expect_xact(0, 8'h60, FPM);
        expect_xact(1, 8'h61, FPM);

        // R2: a partial message is not forwarded
        push(9, 8'h99, 0, FPM-1);
        begin
            bit seen = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (req_valid) seen = 1;
            end
            check(!seen, "R2 partial message held", 64'(seen), 0);
        end
        push(9, 8'h99, FPM-1, 1);
        expect_xact(9, 8'h99, FPM);

        // R9: fill group 7 while group 1 is outstanding, then overflow once
        push(1, 8'hB1, 0, FPM);
        fork
            expect_xact(1, 8'hB1, FPM);
            begin
                repeat (20) @(negedge clk);
                push(7, 8'hC1, 0, FPM);
                push(7, 8'hC2, 0, FPM);
                push(7, 8'hDD, 0, 1);
            end
        join
        check(ovf7 == 1, "R9 overflow pulse count", 64'(ovf7), 1);
        check(ovf_other == 0, "R9 no overflow elsewhere", 64'(ovf_other), 0);
        expect_xact(7, 8'hC1, FPM);
        expect_xact(7, 8'hC2, FPM);
        push(7, 8'hE7, 0, FPM-1);
        begin
            bit seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (req_valid) seen = 1;
            end
            check(!seen, "R9 dropped flit not stored", 64'(seen), 0);
        end
        push(7, 8'hE7, FPM-1, 1);
        expect_xact(7, 8'hE7, FPM);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule